// File: doc/BRIEF.md
# Free-Running Interval Timer with Wake Request

This block is a 16-bit down counter that runs freely while its run control is high, decrementing by one on each pulse from one of two count-source strobes. A two-bit period field picks where the underflow is taken: at the borrow out of counter bit 8, 10, 12 or 15. The counter never reloads. It wraps through all ones and keeps going, so underflows repeat every 512, 2048, 8192 or 65536 source pulses, counted from the moment the run control goes high.

Each underflow sets a request flag. The processor clears the flag in one of two ways: by acknowledging the interrupt, or by testing the flag with a conditional-skip operation. When the power-down indicator is high, an underflow also produces a one-cycle wake pulse for the power controller. Counter bit 4 is brought out as a divided clock tap for a downstream divider. Dropping the run control parks the counter at all ones. All inputs are synchronous to `clk`, and the count sources are single-cycle enable strobes.

Top module: `t3_wake_timer`

## Requirements
- R1: While `run_i` is high, each selected source strobe sampled high at a clock edge decrements the 16-bit counter by one, wrapping from 0 to 16'hFFFF. With no selected strobe, the counter holds.
- R2: `src_sel_i`=0 selects `src_a_i` and `src_sel_i`=1 selects `src_b_i`. The unselected strobe has no effect on the counter, the flag or the tap.
- R3: While `run_i` is low, the counter is forced to 16'hFFFF and nothing counts. After `run_i` rises, the first underflow needs a full period again.
- R4: An underflow occurs on a counted strobe that finds counter bits [k:0] all zero, where `per_sel_i` 0,1,2,3 gives k = 8, 10, 12, 15. From a stop, the first underflow falls on strobe 512, 2048, 8192 or 65536.
- R5: Counting continues through an underflow, and the next underflow follows after exactly one further period of strobes.
- R6: `req_flag_o` rises in the cycle after an underflow and stays high until it is cleared.
- R7: A high `irq_ack_i` clears `req_flag_o` at the next edge.
- R8: A high `skip_test_i` while `req_flag_o` is high clears it at the next edge.
- R9: An underflow in the same cycle as a clear request leaves `req_flag_o` high.
- R10: `wake_o` is high for exactly the one cycle after an underflow during which `pd_mode_i` was high. It stays low when `pd_mode_i` is low.
- R11: `tap_o` equals counter bit 4, so after n strobes from a stop it equals bit 4 of (16'hFFFF − n) mod 2^16.
- R12: After synchronous reset (`rst_n` low at an edge), the counter is 16'hFFFF, `tap_o` is 1, and `req_flag_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Run control; low stops and parks the counter at all ones |
| src_sel_i | input | 1 | Count source select (0 = src_a_i, 1 = src_b_i) |
| per_sel_i | input | 2 | Underflow point: bit 8, 10, 12 or 15 |
| src_a_i | input | 1 | Count strobe A |
| src_b_i | input | 1 | Count strobe B |
| pd_mode_i | input | 1 | Power-down indicator; gates the wake pulse |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| skip_test_i | input | 1 | Skip-test pulse; clears the flag when it is set |
| req_flag_o | output | 1 | Underflow request flag |
| wake_o | output | 1 | One-cycle wake request |
| tap_o | output | 1 | Counter bit 4 clock tap |

## Verification
The assertions assume that the count strobes, the select fields and the clear pulses are synchronous to `clk` and settle before each edge. They also assume that `per_sel_i` and `src_sel_i` stay steady while the counter runs, so that a period is measured against a single underflow point. The stimulus changes every input only on the falling clock edge. It always stops the counter before it changes the period or the source, and it leaves the strobes low throughout reset, so no counting happens in the reset cycle that the first checked cycle looks back on.

// File: rtl/t3_pkg.sv
// Package t3_pkg
// Shared encodings for the interval timer: the period-select codes and the
// count-source codes. Assumes a two-bit period field and two sources.
package t3_pkg;

    // Underflow point selection, in order of rising period
    typedef enum logic [1:0] {
        PER_B8   = 2'd0,
        PER_B10  = 2'd1,
        PER_B12  = 2'd2,
        PER_FULL = 2'd3
    } per_sel_e;

    // Count source selection
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_sel_e;

    localparam int PER_CODES = 4;

endpackage

// File: rtl/t3_tick_gate.sv
// Module t3_tick_gate
// Picks one of two count strobes and gates it with the run control, giving
// the single-cycle decrement enable for the counter.
// Assumes both strobes are synchronous enables, one cycle wide per count.
module t3_tick_gate
    import t3_pkg::*;
(
    input  logic run_i,
    input  logic src_sel_i,
    input  logic src_a_i,
    input  logic src_b_i,
    output logic tick_o
);

    src_sel_e sel;

    // Decode the source code and qualify the chosen strobe with the run bit
    always_comb begin
        sel    = src_sel_e'(src_sel_i);
        tick_o = run_i & ((sel == SRC_B) ? src_b_i : src_a_i);
    end

endmodule

// File: rtl/t3_down_counter.sv
// Module t3_down_counter
// Free-running WIDTH-bit down counter. It decrements on tick_i and is parked
// at all ones while run_i is low. An underflow is flagged combinationally
// when a tick finds the low bits [k:0] zero, where k is picked by
// per_sel_i from the BIT0..BIT3 parameters. There is no reload: the counter
// keeps wrapping through all ones.
// Assumes per_sel_i is steady while counting.
module t3_down_counter
    import t3_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int BIT0  = 8,
    parameter int BIT1  = 10,
    parameter int BIT2  = 12,
    parameter int BIT3  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [1:0]       per_sel_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             uf_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam int BIT_TBL [PER_CODES] = '{BIT0, BIT1, BIT2, BIT3};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] mask_tbl [PER_CODES];
    logic [WIDTH-1:0] sel_mask;

    // Build one low-bit mask per period code
    for (genvar g = 0; g < PER_CODES; g++) begin : g_mask
        assign mask_tbl[g] = ALL_ONES >> (WIDTH - 1 - BIT_TBL[g]);
    end

    // Pick the mask for the active period and detect the borrow out of bit k
    always_comb begin
        sel_mask = mask_tbl[per_sel_i];
        uf_o     = tick_i & ((cnt_q & sel_mask) == '0);
    end

    // Counter state: reset and stop park at all ones, a tick decrements
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= ALL_ONES;
        end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R3: a stopped counter reads all ones on the next cycle
    a_r3_stop_parks: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == ALL_ONES));

    // R1: a tick while running lowers the count by exactly one
    a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R1: no tick while running leaves the count unchanged
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_q));

    // R5: after an underflow the selected low bits are all ones
    a_r5_wraps_on: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && run_i) |=> ((cnt_q & $past(sel_mask)) == $past(sel_mask)));

endmodule

// File: rtl/t3_req_flag.sv
// Module t3_req_flag
// Request flag for the timer underflow. It is set by set_i and cleared by an
// interrupt acknowledge, or by a skip test that finds the flag high. Set has
// priority over a clear in the same cycle.
// Assumes the clear inputs are single-cycle pulses.
module t3_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic skip_i,
    output logic flag_o
);

    logic flag_q;
    logic clr;

    // A skip test clears only a flag that it finds set
    always_comb begin
        clr = ack_i | (skip_i & flag_q);
    end

    // Flag state with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R6, R9: a set request always leaves the flag high
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R7: an acknowledge without a set clears the flag
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !flag_q);

    // R8: a skip test on a set flag clears it
    a_r8_skip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_i && flag_q && !set_i) |=> !flag_q);

    // R6: with no set and no clear input, the flag holds
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !ack_i && !skip_i) |=> $stable(flag_q));

endmodule

// File: rtl/t3_wake_timer.sv
// Module t3_wake_timer
// Top of the interval timer: source gating, the free-running down counter,
// the request flag, the registered wake pulse and the clock tap.
// Assumes all inputs are synchronous to clk, and that the period and source
// selections change only while run_i is low.
module t3_wake_timer #(
    parameter int WIDTH   = 16,
    parameter int TAP_BIT = 4,
    parameter int BIT0    = 8,
    parameter int BIT1    = 10,
    parameter int BIT2    = 12,
    parameter int BIT3    = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       src_sel_i,
    input  logic [1:0] per_sel_i,
    input  logic       src_a_i,
    input  logic       src_b_i,
    input  logic       pd_mode_i,
    input  logic       irq_ack_i,
    input  logic       skip_test_i,
    output logic       req_flag_o,
    output logic       wake_o,
    output logic       tap_o
);

    logic             tick;
    logic             uf;
    logic [WIDTH-1:0] cnt;
    logic             wake_q;

    t3_tick_gate u_gate (
        .run_i     (run_i),
        .src_sel_i (src_sel_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .tick_o    (tick)
    );

    t3_down_counter #(
        .WIDTH (WIDTH),
        .BIT0  (BIT0),
        .BIT1  (BIT1),
        .BIT2  (BIT2),
        .BIT3  (BIT3)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .tick_i    (tick),
        .per_sel_i (per_sel_i),
        .cnt_o     (cnt),
        .uf_o      (uf)
    );

    t3_req_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (uf),
        .ack_i  (irq_ack_i),
        .skip_i (skip_test_i),
        .flag_o (req_flag_o)
    );

    // Wake pulse: one cycle after an underflow taken in power-down mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= uf & pd_mode_i;
        end
    end

    assign wake_o = wake_q;
    assign tap_o  = cnt[TAP_BIT];

    // R10: a wake pulse only accompanies a freshly set flag
    a_r10_wake_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> req_flag_o);

    // R10: outside power-down mode no wake pulse follows
    a_r10_no_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_mode_i |=> !wake_o);

    // R3: a stopped timer neither sets the flag nor wakes
    a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !req_flag_o) |=> (!req_flag_o && !wake_o));

    // R11: while stopped, the tap reads one
    a_r11_tap_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> tap_o);

endmodule

// File: tb/t3_wake_timer_tb.sv
// Bench for t3_wake_timer: a table of period/source/strobe-count rows,
// followed by directed tests for reset, repetition, clear paths, priority
// and the wake pulse.
module t3_wake_timer_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    typedef struct packed {
        logic [1:0]  per;
        logic        srcb;
        logic [31:0] n;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{per: 2'd0, srcb: 1'b0, n: 32'd100},
        '{per: 2'd0, srcb: 1'b1, n: 32'd511},
        '{per: 2'd0, srcb: 1'b0, n: 32'd512},
        '{per: 2'd1, srcb: 1'b1, n: 32'd2047},
        '{per: 2'd1, srcb: 1'b0, n: 32'd2048},
        '{per: 2'd2, srcb: 1'b0, n: 32'd8191},
        '{per: 2'd2, srcb: 1'b1, n: 32'd8192},
        '{per: 2'd3, srcb: 1'b0, n: 32'd1000},
        '{per: 2'd3, srcb: 1'b1, n: 32'd65536}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       src_sel_i = 1'b0;
    logic [1:0] per_sel_i = 2'd0;
    logic       src_a_i = 1'b0;
    logic       src_b_i = 1'b0;
    logic       pd_mode_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic       skip_test_i = 1'b0;
    logic       req_flag_o;
    logic       wake_o;
    logic       tap_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    t3_wake_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .src_sel_i   (src_sel_i),
        .per_sel_i   (per_sel_i),
        .src_a_i     (src_a_i),
        .src_b_i     (src_b_i),
        .pd_mode_i   (pd_mode_i),
        .irq_ack_i   (irq_ack_i),
        .skip_test_i (skip_test_i),
        .req_flag_o  (req_flag_o),
        .wake_o      (wake_o),
        .tap_o       (tap_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Period in strobes for each select code (R4)
    function automatic int period_of(input logic [1:0] p);
        case (p)
            2'd0:    return 512;
            2'd1:    return 2048;
            2'd2:    return 8192;
            default: return 65536;
        endcase
    endfunction

    // Expected tap after n strobes from a stop (R11)
    function automatic logic tap_after(input int n);
        logic [15:0] v;
        v = 16'hFFFF - n[15:0];
        return v[4];
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Hold the chosen strobe for n edges, then drop it at a falling edge
    task automatic strobes(input int n, input logic use_b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_a_i = ~use_b;
            src_b_i = use_b;
        end
        @(negedge clk);
        src_a_i = 1'b0;
        src_b_i = 1'b0;
    endtask

    // Stop, load the configuration, clear the flag, then run
    task automatic restart(input logic [1:0] per, input logic srcb);
        @(negedge clk);
        run_i     = 1'b0;
        per_sel_i = per;
        src_sel_i = srcb;
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        run_i     = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(req_flag_o, 1'b0, "R12 flag");
        check(wake_o, 1'b0, "R12 wake");
        check(tap_o, 1'b1, "R12 tap");
        rst_n = 1'b1;

        // R4, R11, R1, R2: table walk
        for (int v = 0; v < NVEC; v++) begin
            restart(VECS[v].per, VECS[v].srcb);
            strobes(int'(VECS[v].n), VECS[v].srcb);
            check(req_flag_o, (int'(VECS[v].n) >= period_of(VECS[v].per)) ? 1'b1 : 1'b0, "R4 flag");
            check(tap_o, tap_after(int'(VECS[v].n)), "R11 tap");
        end

        // R2: the unselected strobe is ignored
        restart(2'd0, 1'b0);
        strobes(600, 1'b1);
        check(req_flag_o, 1'b0, "R2 flag");
        check(tap_o, 1'b1, "R2 tap");

        // R7, R6, R5: ack clears, the flag holds, counting continues
        restart(2'd0, 1'b0);
        strobes(512, 1'b0);
        check(req_flag_o, 1'b1, "R6 set");
        repeat (5) @(negedge clk);
        check(req_flag_o, 1'b1, "R6 held");
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        check(req_flag_o, 1'b0, "R7 ack");
        strobes(511, 1'b0);
        check(req_flag_o, 1'b0, "R5 early");
        strobes(1, 1'b0);
        check(req_flag_o, 1'b1, "R5 second");

        // R8: the skip test clears a set flag
        skip_test_i = 1'b1;
        @(negedge clk);
        skip_test_i = 1'b0;
        check(req_flag_o, 1'b0, "R8 skip");

        // R3: a stop mid-count forces a full period again
        restart(2'd0, 1'b0);
        strobes(300, 1'b0);
        restart(2'd0, 1'b0);
        strobes(511, 1'b0);
        check(req_flag_o, 1'b0, "R3 no early");
        strobes(1, 1'b0);
        check(req_flag_o, 1'b1, "R3 full");

        // R9: an underflow coinciding with an acknowledge keeps the flag
        restart(2'd0, 1'b0);
        strobes(511, 1'b0);
        @(negedge clk);
        src_a_i   = 1'b1;
        irq_ack_i = 1'b1;
        @(negedge clk);
        src_a_i   = 1'b0;
        irq_ack_i = 1'b0;
        check(req_flag_o, 1'b1, "R9 set wins");

        // R10: wake pulse lasts one cycle in power-down mode
        restart(2'd0, 1'b0);
        pd_mode_i = 1'b1;
        strobes(512, 1'b0);
        check(wake_o, 1'b1, "R10 wake");
        @(negedge clk);
        check(wake_o, 1'b0, "R10 one cycle");

        // R10: no wake when awake
        restart(2'd0, 1'b0);
        pd_mode_i = 1'b0;
        strobes(512, 1'b0);
        check(wake_o, 1'b0, "R10 awake");
        check(req_flag_o, 1'b1, "R10 flag");

        // R12: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_flag_o, 1'b0, "R12 flag again");
        check(tap_o, 1'b1, "R12 tap again");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule